// File: doc/BRIEF.md
# Cache-Line Allocate Backup Buffer

This block keeps a short, ordered record of address/value pairs written by a store that allocates a cache line without fetching it. A later invalidate of a cache line may throw that store away. To prevent the loss, the buffer can push the recorded value out to memory first. Software-visible cache state, the memory itself and instruction decode are handled elsewhere. The block only holds the pairs, searches them and issues the write.

Three commands arrive on a shared address/data bus:
- **Append** records a pair, but only when the caller marks the address as cacheable.
- **Line invalidate** looks for the oldest recorded pair in the same 32-byte line. If it finds one, it removes that pair and sends a single write request carrying the pair's own full address and value.
- **Discard** drops every recorded pair and writes nothing.

The write request uses a valid/ready handshake. While a write is outstanding, the block refuses new commands and shows this on `cmd_ready`.

Top module: `line_backup_buf`

## Requirements
- R1: An append with `cmd_cacheable` low stores nothing: `empty`, `full` and later invalidate results are as if the command never came.
- R2: Stored pairs keep their arrival order; a new pair is placed after all existing ones.
- R3: An invalidate matches a stored pair when the two addresses are equal once bits [4:0] are ignored (32-byte lines).
- R4: On a match, only the oldest matching pair is removed. One write request is raised the cycle after the command, with `mem_addr` equal to the pair's full stored address and `mem_data` equal to its stored value.
- R5: Discard empties the buffer in one cycle and raises no write request.
- R6: `DEPTH` (default 8) pairs fit. `full` is high when `DEPTH` pairs are held. A cacheable append while full is dropped, and `overflow` is high for exactly the following cycle.
- R7: When a pair is removed from the middle, the later pairs move forward and keep their relative order.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_addr` and `mem_data` stay stable. While a write is pending, `cmd_ready` is low and all commands are ignored. `cmd_ready` returns the cycle after the handshake.
- R9: An invalidate with no matching pair changes nothing, raises no write, and leaves `cmd_ready` high.
- R10: When several commands are asserted in one accepted cycle, only one is carried out. Discard wins over invalidate, and invalidate wins over append.
- R11: After reset, `empty` is 1, `full`, `overflow` and `mem_valid` are 0, and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_append | input | 1 | Append command |
| cmd_inval | input | 1 | Line invalidate command |
| cmd_discard | input | 1 | Discard-all command |
| cmd_cacheable | input | 1 | Append target is cacheable |
| cmd_addr | input | AW | Command address |
| cmd_data | input | DW | Append value |
| cmd_ready | output | 1 | Commands are accepted this cycle |
| mem_valid | output | 1 | Write request pending |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | AW | Write address |
| mem_data | output | DW | Write value |
| full | output | 1 | DEPTH pairs held |
| empty | output | 1 | No pair held |
| overflow | output | 1 | Previous cycle dropped an append because the buffer was full |

## Verification
Two functions meet in one cycle in two ways. A discard can land together with an invalidate that would hit, and an invalidate can land together with a cacheable append; both cases are driven on purpose and also occur in random traffic. The behavioural queue model applies the priority order and predicts whether a write appears and how many pairs remain. A further collision is a command presented while a write stalls on `mem_ready`; the model expects that command to vanish.

// File: rtl/line_backup_buf.sv
module line_backup_buf #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DEPTH = 8,
  parameter int LINE_BITS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_append,
  input  logic          cmd_inval,
  input  logic          cmd_discard,
  input  logic          cmd_cacheable,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  output logic          cmd_ready,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          full,
  output logic          empty,
  output logic          overflow
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [CW-1:0] cnt;
  logic          pend, ovf_q;
  logic [AW-1:0] wa_q;
  logic [DW-1:0] wd_q;
  logic          hit;
  logic [IW-1:0] hit_idx;

  wire do_disc  = !pend & cmd_discard;
  wire do_inv   = !pend & cmd_inval & !cmd_discard;
  wire do_app   = !pend & cmd_append & cmd_cacheable & !cmd_inval & !cmd_discard;
  wire is_full  = (cnt == CW'(DEPTH));
  wire do_rm    = do_inv & hit;
  wire do_store = do_app & !is_full;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (CW'(i) < cnt && addr_q[i][AW-1:LINE_BITS] == cmd_addr[AW-1:LINE_BITS]) begin
        hit = 1'b1;
        hit_idx = IW'(i);
      end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [AW-1:0] nxt_a;
    logic [DW-1:0] nxt_d;
    if (g == DEPTH - 1) begin : g_last
      assign nxt_a = addr_q[g];
      assign nxt_d = data_q[g];
    end else begin : g_mid
      assign nxt_a = addr_q[g+1];
      assign nxt_d = data_q[g+1];
    end
    always_ff @(posedge clk) begin
      if (do_rm && IW'(g) >= hit_idx) begin
        addr_q[g] <= nxt_a;
        data_q[g] <= nxt_d;
      end else if (do_store && CW'(g) == cnt) begin
        addr_q[g] <= cmd_addr;
        data_q[g] <= cmd_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      pend  <= 1'b0;
      ovf_q <= 1'b0;
      wa_q  <= '0;
      wd_q  <= '0;
    end else begin
      ovf_q <= do_app & is_full;
      if (do_disc) cnt <= '0;
      else if (do_rm) cnt <= cnt - 1'b1;
      else if (do_store) cnt <= cnt + 1'b1;
      if (pend && mem_ready) pend <= 1'b0;
      if (do_rm) begin
        pend <= 1'b1;
        wa_q <= addr_q[hit_idx];
        wd_q <= data_q[hit_idx];
      end
    end
  end

  assign cmd_ready = !pend;
  assign mem_valid = pend;
  assign mem_addr  = wa_q;
  assign mem_data  = wd_q;
  assign full      = is_full;
  assign empty     = (cnt == '0);
  assign overflow  = ovf_q;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
  assert_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready && cmd_discard |=> empty && !mem_valid);
  assert_noncache_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_append && !cmd_cacheable && !cmd_inval && !cmd_discard |=> $stable(cnt));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_ovf_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> full);
  assert_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready && cmd_inval && !cmd_discard && !hit |=> cmd_ready && $stable(cnt));
endmodule

// File: tb/line_backup_buf_test.sv
module line_backup_buf_test;
  localparam int D = 8;
  logic clk = 0, rst_n = 0;
  logic app = 0, inv = 0, disc = 0, cach = 0, rdy = 0;
  logic [31:0] addr = 0, data = 0;
  logic cmd_ready, mem_valid, full, empty, overflow;
  logic [31:0] mem_addr, mem_data;
  int n_chk = 0, n_bad = 0, cycles = 0;

  always #4 clk = ~clk;

  line_backup_buf #(.AW(32), .DW(32), .DEPTH(D), .LINE_BITS(5)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_append(app), .cmd_inval(inv), .cmd_discard(disc),
    .cmd_cacheable(cach), .cmd_addr(addr), .cmd_data(data), .cmd_ready(cmd_ready),
    .mem_valid(mem_valid), .mem_ready(rdy), .mem_addr(mem_addr), .mem_data(mem_data),
    .full(full), .empty(empty), .overflow(overflow));

  logic [31:0] qa[$], qd[$];
  bit m_pend = 0, m_ovf = 0;
  logic [31:0] m_wa = 0, m_wd = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      qa.delete(); qd.delete(); m_pend = 0; m_ovf = 0;
    end else begin
      bit take, nov;
      take = !m_pend; nov = 0;
      if (m_pend && rdy) m_pend = 0;
      if (take) begin
        if (disc) begin qa.delete(); qd.delete(); end
        else if (inv) begin
          for (int k = 0; k < qa.size(); k++)
            if ((qa[k] >> 5) == (addr >> 5)) begin
              m_wa = qa[k]; m_wd = qd[k];
              qa.delete(k); qd.delete(k);
              m_pend = 1;
              break;
            end
        end else if (app && cach) begin
          if (qa.size() == D) nov = 1;
          else begin qa.push_back(addr); qd.push_back(data); end
        end
      end
      m_ovf = nov;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic compare();
    chk("R8 cmd_ready", 32'(cmd_ready), 32'(!m_pend));
    chk("R4 mem_valid", 32'(mem_valid), 32'(m_pend));
    if (m_pend) begin
      chk("R4 mem_addr", mem_addr, m_wa);
      chk("R4 mem_data", mem_data, m_wd);
    end
    chk("R6 full", 32'(full), 32'(qa.size() == D));
    chk("R1 empty", 32'(empty), 32'(qa.size() == 0));
    chk("R6 overflow", 32'(overflow), 32'(m_ovf));
  endtask

  task automatic cyc(bit a, bit i, bit d, bit c, logic [31:0] ad, logic [31:0] da, bit r);
    app = a; inv = i; disc = d; cach = c; addr = ad; data = da; rdy = r;
    @(negedge clk);
    compare();
  endtask

  function automatic logic [31:0] la(int line, int off);
    return 32'h0000_4000 | 32'(line << 5) | 32'(off << 2);
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: reset state
    chk("R11 empty", 32'(empty), 1);
    chk("R11 full", 32'(full), 0);
    chk("R11 mem_valid", 32'(mem_valid), 0);
    chk("R11 cmd_ready", 32'(cmd_ready), 1);
    chk("R11 overflow", 32'(overflow), 0);
    // R1: non-cacheable appends are ignored
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0, la(0, k), 32'h11 + k, 1);
    cyc(0, 1, 0, 0, la(0, 0), 0, 1);
    // R2, R3, R4, R7: ordering, line match, oldest only, compaction
    cyc(1, 0, 0, 1, la(0, 1), 32'hA0, 1);
    cyc(1, 0, 0, 1, la(1, 2), 32'hB1, 1);
    cyc(1, 0, 0, 1, la(0, 5), 32'hC0, 1);
    cyc(1, 0, 0, 1, la(2, 3), 32'hD2, 1);
    cyc(0, 1, 0, 0, la(0, 7), 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(0, 1, 0, 0, la(0, 0), 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(0, 1, 0, 0, la(1, 0), 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    // R9: miss
    cyc(0, 1, 0, 0, la(5, 0), 0, 1);
    cyc(0, 1, 0, 0, la(2, 1), 0, 0);
    // R8: stall; commands during the pending write are ignored
    cyc(1, 0, 0, 1, la(3, 0), 32'hEE, 0);
    cyc(0, 0, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    // R6: fill beyond depth
    for (int k = 0; k < D + 2; k++) cyc(1, 0, 0, 1, la(k % 4, k % 8), 32'h100 + k, 1);
    // R10: discard beats invalidate, invalidate beats append
    cyc(0, 1, 1, 0, la(0, 0), 0, 1);
    cyc(1, 0, 0, 1, la(1, 1), 32'h55, 1);
    cyc(1, 1, 0, 1, la(1, 4), 32'h66, 1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    // R5: discard
    cyc(1, 0, 0, 1, la(2, 2), 32'h77, 1);
    cyc(0, 0, 1, 0, 0, 0, 1);
    // random traffic covering all of R1..R10
    for (int k = 0; k < 4000; k++) begin
      int p;
      p = $urandom % 16;
      cyc(p < 8, (p >= 6 && p < 13), (p == 13 || p == 5), ($urandom % 4) != 0,
          la($urandom % 4, $urandom % 8), $urandom, ($urandom % 3) != 0);
    end
    finish_run();
  end
endmodule